// File: doc/BRIEF.md
# UART Receive Queue and Status Controller

This block sits behind the receive shift register of a serial port. Each finished character arrives with its data byte and its break, framing and parity flags. The block keeps these in a four-entry queue, which is three queue positions plus one holding position. The processor reads the oldest character through the register port and removes it with a separate pop strobe.

The block also does four other jobs:
- It reports error status in one of two ways. Character mode shows the flags of the oldest character only. Block mode shows the OR of the flags of every character seen at the head since the last clear.
- It keeps a sticky overrun flag.
- It picks whether the interrupt/DMA request means "data ready" or "queue full".
- It drives an active-low request-to-send line. The line is negated when a new start bit appears while the queue is full, and asserted again once an entry frees up.

The first mode register and a second mode register share one address. A pointer selects between them. The pointer starts on the first register and moves to the second after any access to the first.

Top module: `rxq_ctl`

## Requirements
- R1: After reset, rts_n is 0 and req is 0. Both mode registers read 0x00. The status register at address 1 reads 0x00.
- R2: Accesses to address 0 go to mode register 1 while the pointer is clear. Any read or write there sets the pointer, and later accesses go to mode register 2. Writing address 2 with wdata[6:4]=3'b001 clears the pointer. Mode register 1 layout: bit 7 receiver RTS enable, bit 6 request select, bit 5 error mode, bits 4:3 parity mode, bit 2 parity type, bits 1:0 character length.
- R3: The queue returns characters in arrival order and holds up to 4. Address 3 reads the oldest data byte, or 0x00 when the queue is empty. A pop removes the oldest entry. A pop on an empty queue is ignored. Status bit 0 is "not empty" and bit 1 is "full".
- R4: A character that arrives while 4 are held is discarded and sets status bit 4 (overrun). Only a write of address 2 with wdata[6:4]=3'b101 clears that bit.
- R5: Suppose mode bit 7 is 1 and tx_rts_ctl is 0. A start_det pulse while the queue is full and not popped drives rts_n to 1 on the next edge. A start_det pulse while the queue has room leaves rts_n at 0.
- R6: With receiver RTS control in force, rts_n returns to 0 on the edge at which the queue stops being full.
- R7: When mode bit 7 is 0, or when tx_rts_ctl is 1, the receiver leaves rts_n unchanged.
- R8: With mode bit 6 at 0, req is high whenever the queue is not empty. With mode bit 6 at 1, req is high only when the queue holds 4 characters.
- R9: With mode bit 5 at 0, status bits 7, 6 and 5 are the break, framing and parity flags of the oldest character. They are 0 when the queue is empty.
- R10: With mode bit 5 at 1, status bits 7 to 5 are the OR of the flags of every character that has been oldest since the last clear command (wdata[6:4]=3'b101). The current oldest character is included.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 2 | Register address: 0 mode, 1 status, 2 command, 3 data |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data, combinational from the address |
| chr_valid | input | 1 | One-cycle strobe: a received character is present |
| chr_data | input | 8 | Received data byte |
| chr_brk | input | 1 | Received break flag |
| chr_fe | input | 1 | Framing error flag |
| chr_pe | input | 1 | Parity error flag |
| start_det | input | 1 | One-cycle strobe: a valid start bit was detected |
| pop | input | 1 | Remove the oldest character |
| tx_rts_ctl | input | 1 | Transmitter side has RTS control enabled |
| rts_n | output | 1 | Request-to-send, active low |
| req | output | 1 | Receive interrupt/DMA request |

## Verification
The checker relies on three things about the inputs. The register port never asserts read and write in the same cycle. The command and mode addresses are never accessed together. pop, chr_valid and start_det are single-cycle strobes, sampled at the edge.

The stimulus keeps to these rules. It drives every input from the falling edge and raises at most one register strobe per task. It holds each strobe for exactly one cycle. The RTS checks use a start_det pulse with no character and no pop in the same cycle, so the full condition is unambiguous.

// File: rtl/rxq_pkg.sv
`timescale 1ns/1ps
package rxq_pkg;

  localparam logic [1:0] ADR_MODE = 2'd0;
  localparam logic [1:0] ADR_STAT = 2'd1;
  localparam logic [1:0] ADR_CMD  = 2'd2;
  localparam logic [1:0] ADR_DATA = 2'd3;

  localparam logic [2:0] CMD_RST_PTR = 3'b001;
  localparam logic [2:0] CMD_RST_ERR = 3'b101;

  typedef struct packed {
    logic brk;
    logic fe;
    logic pe;
  } rxq_flags_t;

  typedef struct packed {
    logic [7:0] data;
    rxq_flags_t fl;
  } rxq_entry_t;

  // occupancy after one edge; pop only counted when queue non-empty
  function automatic int unsigned occ_after(int unsigned occ, logic push_ok, logic pop_ok);
    int unsigned r;
    r = occ;
    if (push_ok) r = r + 1;
    if (pop_ok)  r = r - 1;
    return r;
  endfunction

  function automatic logic req_pick(logic sel_full, logic full, logic empty);
    return sel_full ? full : !empty;
  endfunction

  function automatic logic rts_step(logic en, logic start, logic full_nxt, logic cur);
    if (!en)              return cur;
    if (start && full_nxt) return 1'b1;
    if (!full_nxt)        return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/rxq_fifo.sv
`timescale 1ns/1ps
module rxq_fifo
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         pop,
  input  rxq_entry_t                   din,
  output rxq_entry_t                   head,
  output logic [$clog2(DEPTH+1)-1:0]   count,
  output logic                         full,
  output logic                         empty,
  output logic                         push_ok,
  output logic                         pop_ok
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t     mem [DEPTH];
  logic [AW-1:0]  wr_ptr, rd_ptr;

  assign full    = (count == CW'(DEPTH));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = empty ? '0 : mem[rd_ptr];

  function automatic logic [AW-1:0] wrap_inc(logic [AW-1:0] p);
    return (p == AW'(DEPTH-1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wrap_inc(wr_ptr);
      if (pop_ok)  rd_ptr <= wrap_inc(rd_ptr);
      count <= CW'(occ_after(int'(count), push_ok, pop_ok));
    end
  end

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                mem[i] <= '0;
      else if (push_ok && wr_ptr == AW'(i))      mem[i] <= din;
    end
  end
endmodule

// File: rtl/rxq_mode.sv
`timescale 1ns/1ps
module rxq_mode (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       acc_wr,
  input  logic       acc_rd,
  input  logic [7:0] wdata,
  input  logic       rst_ptr,
  output logic       ptr,
  output logic       rts_en,
  output logic       sel_full,
  output logic       err_blk,
  output logic [7:0] rdata
);
  logic [7:0] mr1, mr2;

  assign rts_en   = mr1[7];
  assign sel_full = mr1[6];
  assign err_blk  = mr1[5];
  assign rdata    = ptr ? mr2 : mr1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mr1 <= '0;
      mr2 <= '0;
      ptr <= 1'b0;
    end else begin
      if (acc_wr) begin
        if (ptr) mr2 <= wdata;
        else     mr1 <= wdata;
      end
      if (rst_ptr)                   ptr <= 1'b0;
      else if ((acc_wr || acc_rd) && !ptr) ptr <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_errstat.sv
`timescale 1ns/1ps
module rxq_errstat
  import rxq_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       err_blk,
  input  rxq_flags_t head_fl,
  input  logic       ovr_evt,
  input  logic       clr,
  output rxq_flags_t stat_fl,
  output logic       ovr
);
  rxq_flags_t acc;

  assign stat_fl = err_blk ? (acc | head_fl) : head_fl;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      ovr <= 1'b0;
    end else if (clr) begin
      acc <= '0;
      ovr <= 1'b0;
    end else begin
      acc <= acc | head_fl;
      if (ovr_evt) ovr <= 1'b1;
    end
  end
endmodule

// File: rtl/rxq_ctl.sv
`timescale 1ns/1ps
module rxq_ctl
  import rxq_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_rd,
  input  logic [1:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       chr_valid,
  input  logic [7:0] chr_data,
  input  logic       chr_brk,
  input  logic       chr_fe,
  input  logic       chr_pe,
  input  logic       start_det,
  input  logic       pop,
  input  logic       tx_rts_ctl,
  output logic       rts_n,
  output logic       req
);
  localparam int CW = $clog2(DEPTH+1);

  rxq_entry_t    din, head;
  logic [CW-1:0] count;
  logic          fifo_full, fifo_empty, push_ok, pop_ok;
  logic          mr_acc_wr, mr_acc_rd, mr_access, cmd_wr, rst_ptr, clr_err;
  logic          ptr, rts_en, sel_full, err_blk, rts_en_eff, full_nxt, ovr_evt, ovr;
  logic [7:0]    mode_rdata;
  rxq_flags_t    stat_fl;

  assign din       = '{data: chr_data, fl: '{brk: chr_brk, fe: chr_fe, pe: chr_pe}};
  assign mr_acc_wr = reg_wr && (reg_addr == ADR_MODE);
  assign mr_acc_rd = reg_rd && (reg_addr == ADR_MODE);
  assign mr_access = mr_acc_wr || mr_acc_rd;
  assign cmd_wr    = reg_wr && (reg_addr == ADR_CMD);
  assign rst_ptr   = cmd_wr && (reg_wdata[6:4] == CMD_RST_PTR);
  assign clr_err   = cmd_wr && (reg_wdata[6:4] == CMD_RST_ERR);
  assign ovr_evt   = chr_valid && fifo_full;

  rxq_fifo #(.DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .push(chr_valid), .pop(pop), .din(din),
    .head(head), .count(count), .full(fifo_full), .empty(fifo_empty),
    .push_ok(push_ok), .pop_ok(pop_ok)
  );

  rxq_mode u_mode (
    .clk(clk), .rst_n(rst_n), .acc_wr(mr_acc_wr), .acc_rd(mr_acc_rd),
    .wdata(reg_wdata), .rst_ptr(rst_ptr), .ptr(ptr), .rts_en(rts_en),
    .sel_full(sel_full), .err_blk(err_blk), .rdata(mode_rdata)
  );

  rxq_errstat u_err (
    .clk(clk), .rst_n(rst_n), .err_blk(err_blk), .head_fl(head.fl),
    .ovr_evt(ovr_evt), .clr(clr_err), .stat_fl(stat_fl), .ovr(ovr)
  );

  // receiver RTS control only when the transmitter does not also claim it
  assign rts_en_eff = rts_en && !tx_rts_ctl;
  assign full_nxt   = (occ_after(int'(count), push_ok, pop_ok) == DEPTH);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rts_n <= 1'b0;
    else        rts_n <= rts_step(rts_en_eff, start_det, full_nxt, rts_n);
  end

  assign req = req_pick(sel_full, fifo_full, fifo_empty);

  always_comb begin
    unique case (reg_addr)
      ADR_MODE: reg_rdata = mode_rdata;
      ADR_STAT: reg_rdata = {stat_fl.brk, stat_fl.fe, stat_fl.pe, ovr, 2'b00, fifo_full, !fifo_empty};
      ADR_DATA: reg_rdata = head.data;
      default:  reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rxq_ctl_chk.sv
`timescale 1ns/1ps
module rxq_ctl_chk #(
  parameter int DEPTH = 4
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       rts_en_eff,
  input logic                       start_det,
  input logic                       pop,
  input logic                       fifo_full,
  input logic                       fifo_empty,
  input logic [$clog2(DEPTH+1)-1:0] count,
  input logic                       rts_n,
  input logic                       req,
  input logic                       sel_full,
  input logic                       ovr,
  input logic                       clr_err,
  input logic                       ptr,
  input logic                       mr_access,
  input logic                       rst_ptr,
  input logic                       err_blk,
  input logic [2:0]                 stat_fl
);
  localparam int CW = $clog2(DEPTH+1);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
    count <= CW'(DEPTH));

  a_r2_ptr_advance: assert property (@(posedge clk) disable iff (!rst_n)
    (mr_access && !ptr && !rst_ptr) |=> ptr);

  a_r2_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
    rst_ptr |=> !ptr);

  a_r4_overrun_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !clr_err) |=> ovr);

  a_r5_rts_negate: assert property (@(posedge clk) disable iff (!rst_n)
    (rts_en_eff && start_det && fifo_full && !pop) |=> rts_n);

  a_r6_rts_reassert: assert property (@(posedge clk) disable iff (!rst_n)
    rts_en_eff |=> (fifo_full || !rts_n));

  a_r7_rts_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !rts_en_eff |=> $stable(rts_n));

  a_r8_req_source: assert property (@(posedge clk) disable iff (!rst_n)
    req == (sel_full ? fifo_full : !fifo_empty));

  a_r10_block_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (err_blk && !clr_err) |=> (!err_blk || ((stat_fl & $past(stat_fl)) == $past(stat_fl))));
endmodule

bind rxq_ctl rxq_ctl_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .rts_en_eff(rts_en_eff), .start_det(start_det),
  .pop(pop), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .count(count),
  .rts_n(rts_n), .req(req), .sel_full(sel_full), .ovr(ovr), .clr_err(clr_err),
  .ptr(ptr), .mr_access(mr_access), .rst_ptr(rst_ptr), .err_blk(err_blk),
  .stat_fl(stat_fl)
);

// File: tb/rxq_ctl_bench.sv
`timescale 1ns/1ps
module rxq_ctl_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_wr = 1'b0, reg_rd = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic       chr_valid = 1'b0;
  logic [7:0] chr_data = 8'h00;
  logic       chr_brk = 1'b0, chr_fe = 1'b0, chr_pe = 1'b0;
  logic       start_det = 1'b0, pop = 1'b0, tx_rts_ctl = 1'b0;
  logic       rts_n, req;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  rxq_ctl u_rxq_ctl (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .chr_valid(chr_valid), .chr_data(chr_data), .chr_brk(chr_brk),
    .chr_fe(chr_fe), .chr_pe(chr_pe), .start_det(start_det), .pop(pop),
    .tx_rts_ctl(tx_rts_ctl), .rts_n(rts_n), .req(req)
  );

  // {push, pop, data[7:0], status[1:0] = {full, ready}, oldest byte[7:0]}
  localparam logic [19:0] VEC [11] = '{
    {1'b1, 1'b0, 8'hA1, 2'b01, 8'hA1},
    {1'b1, 1'b0, 8'hB2, 2'b01, 8'hA1},
    {1'b0, 1'b1, 8'h00, 2'b01, 8'hB2},
    {1'b1, 1'b0, 8'hC3, 2'b01, 8'hB2},
    {1'b1, 1'b0, 8'hD4, 2'b01, 8'hB2},
    {1'b1, 1'b0, 8'hE5, 2'b11, 8'hB2},
    {1'b0, 1'b1, 8'h00, 2'b01, 8'hC3},
    {1'b0, 1'b1, 8'h00, 2'b01, 8'hD4},
    {1'b0, 1'b1, 8'h00, 2'b01, 8'hE5},
    {1'b0, 1'b1, 8'h00, 2'b00, 8'h00},
    {1'b0, 1'b1, 8'h00, 2'b00, 8'h00}
  };

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(string tag, logic [7:0] got, logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h exp %02h", tag, got, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [7:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [7:0] v);
    reg_rd = 1'b1; reg_addr = a;
    #1 v = reg_rdata;
    tick();
    reg_rd = 1'b0;
  endtask

  task automatic set_mr1(logic [7:0] d);
    wr(2'd2, 8'h10);
    wr(2'd0, d);
  endtask

  task automatic push(logic [7:0] d, logic b, logic f, logic p);
    chr_valid = 1'b1; chr_data = d; chr_brk = b; chr_fe = f; chr_pe = p;
    tick();
    chr_valid = 1'b0; chr_brk = 1'b0; chr_fe = 1'b0; chr_pe = 1'b0;
  endtask

  task automatic pop1();
    pop = 1'b1;
    tick();
    pop = 1'b0;
  endtask

  task automatic start1();
    start_det = 1'b1;
    tick();
    start_det = 1'b0;
  endtask

  initial begin
    repeat (25000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk("R1 rts_n", {7'd0, rts_n}, 8'h00);
    chk("R1 req", {7'd0, req}, 8'h00);
    rd(2'd1, v); chk("R1 status", v, 8'h00);
    rd(2'd0, v); chk("R1 mode1", v, 8'h00);
    rd(2'd0, v); chk("R1 mode2", v, 8'h00);

    // R2 pointer sequencing
    wr(2'd2, 8'h10);
    wr(2'd0, 8'hC5);
    wr(2'd0, 8'h3A);
    wr(2'd2, 8'h10);
    rd(2'd0, v); chk("R2 mode1 after ptr reset", v, 8'hC5);
    rd(2'd0, v); chk("R2 mode2 after mode1 read", v, 8'h3A);
    rd(2'd0, v); chk("R2 pointer stays on mode2", v, 8'h3A);
    set_mr1(8'h00);

    // R3 table-driven order, depth, empty pop
    foreach (VEC[i]) begin
      chr_valid = VEC[i][19];
      chr_data  = VEC[i][17:10];
      pop       = VEC[i][18];
      tick();
      chr_valid = 1'b0; pop = 1'b0;
      rd(2'd1, v); chk($sformatf("R3 vec%0d status", i), {6'd0, v[1:0]}, {6'd0, VEC[i][9:8]});
      rd(2'd3, v); chk($sformatf("R3 vec%0d oldest", i), v, VEC[i][7:0]);
    end

    // R8 request source
    chk("R8 empty no req", {7'd0, req}, 8'h00);
    push(8'h01, 1'b0, 1'b0, 1'b0);
    chk("R8 ready req", {7'd0, req}, 8'h01);
    push(8'h02, 1'b0, 1'b0, 1'b0);
    push(8'h03, 1'b0, 1'b0, 1'b0);
    set_mr1(8'h40);
    chk("R8 full-select, 3 held", {7'd0, req}, 8'h00);
    push(8'h04, 1'b0, 1'b0, 1'b0);
    chk("R8 full-select, 4 held", {7'd0, req}, 8'h01);

    // R4 overrun
    push(8'h77, 1'b0, 1'b0, 1'b0);
    rd(2'd1, v); chk("R4 overrun set", v & 8'h13, 8'h13);
    wr(2'd2, 8'h20);
    rd(2'd1, v); chk("R4 other command keeps overrun", v & 8'h10, 8'h10);
    pop1(); pop1(); pop1();
    rd(2'd3, v); chk("R4 discarded byte absent", v, 8'h04);
    pop1();
    rd(2'd1, v); chk("R4 sticky after drain", v, 8'h10);
    wr(2'd2, 8'h50);
    rd(2'd1, v); chk("R4 cleared", v, 8'h00);

    // R5 / R6 RTS flow control
    set_mr1(8'h80);
    push(8'h11, 1'b0, 1'b0, 1'b0);
    push(8'h12, 1'b0, 1'b0, 1'b0);
    push(8'h13, 1'b0, 1'b0, 1'b0);
    start1();
    chk("R5 start with room", {7'd0, rts_n}, 8'h00);
    push(8'h14, 1'b0, 1'b0, 1'b0);
    chk("R5 full without start", {7'd0, rts_n}, 8'h00);
    start1();
    chk("R5 start while full", {7'd0, rts_n}, 8'h01);
    pop1();
    chk("R6 reasserted after pop", {7'd0, rts_n}, 8'h00);

    // R7 no receiver effect
    push(8'h15, 1'b0, 1'b0, 1'b0);
    tx_rts_ctl = 1'b1;
    start1();
    chk("R7 both sides claim RTS", {7'd0, rts_n}, 8'h00);
    tx_rts_ctl = 1'b0;
    set_mr1(8'h00);
    start1();
    chk("R7 receiver RTS off", {7'd0, rts_n}, 8'h00);
    pop1(); pop1(); pop1(); pop1();
    wr(2'd2, 8'h50);

    // R9 character mode
    push(8'h21, 1'b0, 1'b1, 1'b0);
    push(8'h22, 1'b0, 1'b0, 1'b1);
    rd(2'd1, v); chk("R9 oldest framing", v & 8'hE0, 8'h40);
    pop1();
    rd(2'd1, v); chk("R9 next parity", v & 8'hE0, 8'h20);
    pop1();
    rd(2'd1, v); chk("R9 empty clean", v, 8'h00);

    // R10 block mode
    wr(2'd2, 8'h50);
    set_mr1(8'h20);
    push(8'h31, 1'b1, 1'b0, 1'b0);
    push(8'h32, 1'b0, 1'b1, 1'b0);
    rd(2'd1, v); chk("R10 only oldest so far", v & 8'hE0, 8'h80);
    pop1();
    rd(2'd1, v); chk("R10 accumulated", v & 8'hE0, 8'hC0);
    pop1();
    rd(2'd1, v); chk("R10 sticky when empty", v & 8'hE0, 8'hC0);
    wr(2'd2, 8'h50);
    rd(2'd1, v); chk("R10 cleared", v, 8'h00);
    push(8'h33, 1'b0, 1'b0, 1'b1);
    pop1();
    rd(2'd1, v); chk("R10 new block", v & 8'hE0, 8'h20);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule